// File: doc/BRIEF.md
# Request-Gated Frame Burst Source

The block holds one frame of sample words in a small local buffer and sends it to a downstream stage as a series of bursts. Each burst presents the whole frame, one word per clock, with a valid qualifier. A start command loads an iteration count, and that count sets how many bursts are sent. Before each burst the block waits for a one-cycle request pulse from the consumer. After a burst ends, valid drops, the remaining count goes down by one, and the block waits for the next request. When no iterations remain, it raises a one-cycle done flag and goes quiet.

A single-pass mode sends exactly one burst as soon as start is seen, with no request needed. The frame buffer is filled through a plain write port while the block is idle. The frame length is a parameter.

Top module: `burst_src`

## Requirements
- R1: After reset, valid_o and done_o are low and the block is idle: a request pulse with no start produces no valid cycle.
- R2: A start with single_i low loads iter_i. No word is sent until req_i has been sampled high.
- R3: When req_i is sampled high while the block is waiting, valid_o is high for exactly FRAME_LEN consecutive cycles, starting in the next cycle. data_o carries buffer words 0 to FRAME_LEN-1 in address order.
- R4: After each burst valid_o goes low and the block waits for another request. The number of bursts equals the loaded iter_i.
- R5: A request pulse during a burst is ignored and is not queued: once that burst ends, no burst follows until a new request arrives.
- R6: done_o is high for exactly one cycle, in the cycle right after the last word of the final burst. No further valid cycle follows unless there is a new start.
- R7: A start with single_i high sends one burst beginning in the cycle after start, without any request, and then raises done_o.
- R8: A start with single_i low and iter_i equal to 0 sends no burst and raises done_o in the cycle after start.
- R9: A start that arrives while the block is active (waiting or bursting) is ignored.
- R10: A write with wr_en_i high stores wr_data_i at wr_addr_i, and later bursts carry the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start command, sampled when idle |
| single_i | input | 1 | Single-pass mode select, sampled with start |
| iter_i | input | ITER_W (4) | Number of request-gated bursts |
| req_i | input | 1 | Consumer request pulse |
| wr_en_i | input | 1 | Buffer write enable |
| wr_addr_i | input | ADDR_W (4) | Buffer write address |
| wr_data_i | input | DATA_W (24) | Buffer write data |
| data_o | output | DATA_W (24) | Frame word |
| valid_o | output | 1 | Word qualifier |
| done_o | output | 1 | One-cycle completion flag |

## Verification
Gated runs of one, three and fifteen iterations check that the burst count follows the loaded value, including the largest value a 4-bit count can hold. Each burst's length and word order are also checked. A request pulse sent in the middle of a burst tells an ignored request apart from a queued one. A second start sent while the block waits tells an ignored command apart from a restart. Single-pass mode and a zero count are each run on their own, to separate the request-free burst from the path that only raises done. The frame is reloaded with new words between runs, to show the bursts read the buffer and not stale values.

// File: rtl/burst_src_pkg.sv
package burst_src_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_BURST = 2'd2,
    ST_FIN   = 2'd3
  } bsrc_state_e;
endpackage

// File: rtl/burst_src_buf.sv
module burst_src_buf #(
  parameter int DATA_W    = 24,
  parameter int FRAME_LEN = 16,
  localparam int ADDR_W   = $clog2(FRAME_LEN)
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(FRAME_LEN - 1);

  logic [DATA_W-1:0] mem_q [FRAME_LEN];

  always_ff @(posedge clk_i) begin
    if (wr_en_i && wr_addr_i <= LAST_ADDR) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/burst_src_addr.sv
module burst_src_addr #(
  parameter int FRAME_LEN = 16,
  localparam int ADDR_W   = $clog2(FRAME_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(FRAME_LEN - 1);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     addr_q <= '0;
    else if (!en_i || last_o)        addr_q <= '0;
    else                             addr_q <= addr_q + ADDR_W'(1);
  end

  assign addr_o = addr_q;
  assign last_o = en_i && (addr_q == LAST_ADDR);

  AST_ADDR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_q <= LAST_ADDR); // R3
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && addr_q != '0) |-> addr_q == $past(addr_q) + ADDR_W'(1)); // R3
endmodule

// File: rtl/burst_src_ctrl.sv
module burst_src_ctrl
  import burst_src_pkg::*;
#(
  parameter int ITER_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              single_i,
  input  logic [ITER_W-1:0] iter_i,
  input  logic              req_i,
  input  logic              last_i,
  output logic              burst_o,
  output logic              done_o
);
  bsrc_state_e       state_q;
  logic [ITER_W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (single_i) begin
            left_q  <= ITER_W'(1);
            state_q <= ST_BURST;
          end else if (iter_i == '0) begin
            state_q <= ST_FIN;
          end else begin
            left_q  <= iter_i;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: if (req_i) state_q <= ST_BURST;
        ST_BURST: if (last_i) begin
          left_q  <= left_q - ITER_W'(1);
          state_q <= (left_q == ITER_W'(1)) ? ST_FIN : ST_WAIT;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign burst_o = (state_q == ST_BURST);
  assign done_o  = (state_q == ST_FIN);

  AST_WAIT_LEFT_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |-> left_q != '0); // R4
  AST_BURST_LEFT_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BURST) |-> left_q != '0); // R4
  AST_IDLE_HOLDS_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !start_i) |=> state_q == ST_IDLE); // R1
endmodule

// File: rtl/burst_src.sv
module burst_src #(
  parameter int DATA_W    = 24,
  parameter int ITER_W    = 4,
  parameter int FRAME_LEN = 16,
  localparam int ADDR_W   = $clog2(FRAME_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              single_i,
  input  logic [ITER_W-1:0] iter_i,
  input  logic              req_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              done_o
);
  logic              burst;
  logic              last;
  logic [ADDR_W-1:0] rd_addr;

  burst_src_ctrl #(.ITER_W(ITER_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .single_i, .iter_i, .req_i,
    .last_i(last), .burst_o(burst), .done_o
  );

  burst_src_addr #(.FRAME_LEN(FRAME_LEN)) u_addr (
    .clk_i, .rst_ni, .en_i(burst), .addr_o(rd_addr), .last_o(last)
  );

  burst_src_buf #(.DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN)) u_buf (
    .clk_i, .wr_en_i, .wr_addr_i, .wr_data_i,
    .rd_addr_i(rd_addr), .rd_data_o(data_o)
  );

  assign valid_o = burst;

  AST_BURST_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> ($past(req_i) || $past(start_i && single_i))); // R3
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_DONE_NOT_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !valid_o); // R6
  AST_DONE_THEN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !valid_o); // R6
endmodule

// File: tb/burst_src_bench.sv
module burst_src_bench;
  localparam int DATA_W = 24;
  localparam int ITER_W = 4;
  localparam int LEN    = 16;
  localparam int AW     = $clog2(LEN);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, single_i = 1'b0, req_i = 1'b0, wr_en_i = 1'b0;
  logic [ITER_W-1:0] iter_i = '0;
  logic [AW-1:0]     wr_addr_i = '0;
  logic [DATA_W-1:0] wr_data_i = '0;
  logic [DATA_W-1:0] data_o;
  logic              valid_o, done_o;

  always #2 clk = ~clk;

  burst_src u_burst_src (
    .clk_i(clk), .rst_ni, .start_i, .single_i, .iter_i, .req_i,
    .wr_en_i, .wr_addr_i, .wr_data_i, .data_o, .valid_o, .done_o
  );

  logic [DATA_W-1:0] exp_mem [LEN];
  int checks = 0, fails = 0;
  int bursts = 0, run = 0, widx = 0, data_err = 0, len_err = 0, dones = 0;
  bit prev_valid = 0, done_after_valid = 0;
  int cycles = 0;

  always @(negedge clk) begin
    cycles++;
    if (valid_o) begin
      if (widx >= LEN || data_o !== exp_mem[widx]) data_err++;
      widx++;
      run++;
    end else if (prev_valid) begin
      bursts++;
      if (run != LEN) len_err++;
      run = 0;
      widx = 0;
    end
    if (done_o) begin
      dones++;
      done_after_valid = prev_valid;
    end
    prev_valid = valid_o;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clr();
    bursts = 0; data_err = 0; len_err = 0; dones = 0; done_after_valid = 0;
  endtask

  task automatic load_frame(input int seed);
    for (int i = 0; i < LEN; i++) begin
      @(posedge clk); #1;
      wr_en_i = 1'b1;
      wr_addr_i = AW'(i);
      wr_data_i = DATA_W'(seed * 32'h1357 + i * 32'h10203 + 5);
      exp_mem[i] = wr_data_i;
    end
    @(posedge clk); #1;
    wr_en_i = 1'b0;
  endtask

  task automatic do_start(input bit single, input int n);
    @(posedge clk); #1;
    start_i = 1'b1; single_i = single; iter_i = ITER_W'(n);
    @(posedge clk); #1;
    start_i = 1'b0; single_i = 1'b0;
  endtask

  task automatic pulse_req();
    @(posedge clk); #1;
    req_i = 1'b1;
    @(posedge clk); #1;
    req_i = 1'b0;
  endtask

  task automatic t_reset();
    clr();
    @(negedge clk);
    check(valid_o == 1'b0, "R1 valid after reset", int'(valid_o), 0);
    check(done_o == 1'b0, "R1 done after reset", int'(done_o), 0);
    pulse_req();
    cyc(LEN + 8);
    check(bursts == 0 && run == 0, "R1 req while idle", bursts, 0);
  endtask

  task automatic t_gated(input int n);
    clr();
    do_start(1'b0, n);
    cyc(10);
    check(bursts == 0 && run == 0, "R2 no output before req", bursts, 0);
    for (int i = 0; i < n; i++) begin
      pulse_req();
      cyc(LEN + 3);
      check(bursts == i + 1, "R4 burst count per req", bursts, i + 1);
    end
    check(len_err == 0, "R3 burst length", len_err, 0);
    check(data_err == 0, "R3 R10 burst data order", data_err, 0);
    check(dones == 1 && done_after_valid, "R6 done after final burst", dones, 1);
    pulse_req();
    cyc(LEN + 6);
    check(bursts == n && dones == 1, "R6 quiet after done", bursts, n);
  endtask

  task automatic t_req_in_burst();
    clr();
    do_start(1'b0, 2);
    pulse_req();
    cyc(LEN / 2);
    req_i = 1'b1; cyc(1); req_i = 1'b0;
    cyc(3 * LEN);
    check(bursts == 1, "R5 mid-burst req not queued", bursts, 1);
    check(dones == 0, "R5 no early done", dones, 0);
    pulse_req();
    cyc(LEN + 3);
    check(bursts == 2 && dones == 1, "R5 later req served", bursts, 2);
  endtask

  task automatic t_single();
    clr();
    do_start(1'b1, 5);
    cyc(LEN + 3);
    check(bursts == 1 && len_err == 0, "R7 single burst", bursts, 1);
    check(dones == 1 && done_after_valid, "R7 done after single", dones, 1);
    check(data_err == 0, "R7 single data", data_err, 0);
    cyc(2 * LEN);
    check(bursts == 1, "R7 no repeat", bursts, 1);
  endtask

  task automatic t_zero();
    clr();
    @(posedge clk); #1;
    start_i = 1'b1; single_i = 1'b0; iter_i = '0;
    @(posedge clk); #1;
    start_i = 1'b0;
    @(negedge clk);
    check(done_o == 1'b1, "R8 done cycle after start", int'(done_o), 1);
    pulse_req();
    cyc(LEN + 4);
    check(bursts == 0 && dones == 1, "R8 no burst", bursts, 0);
  endtask

  task automatic t_start_busy();
    clr();
    do_start(1'b0, 1);
    cyc(3);
    do_start(1'b1, 3);
    cyc(2 * LEN);
    check(bursts == 0 && run == 0, "R9 start while waiting ignored", bursts, 0);
    pulse_req();
    cyc(LEN / 2);
    do_start(1'b1, 3);
    cyc(2 * LEN);
    check(bursts == 1 && dones == 1, "R9 start while bursting ignored", bursts, 1);
  endtask

  initial begin
    for (int i = 0; i < LEN; i++) exp_mem[i] = '0;
    load_frame(0);
    cyc(3);
    rst_ni = 1'b1;
    cyc(2);
    t_reset();
    load_frame(1);
    t_gated(1);
    load_frame(2);
    t_gated(3);
    t_req_in_burst();
    load_frame(3);
    t_single();
    t_zero();
    t_start_busy();
    load_frame(4);
    t_gated(15);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule